// File: doc/BRIEF.md
# Four-Channel Shared-Counter Pulse-Width Modulator

The block generates four pulse-width outputs from a single free-running counter. The counter is 10 bits wide by default. It advances by one count only in cycles where an external tick input is high, so a prescaler outside the block sets the period length. One full period is 1024 ticks. Each channel compares the shared count against its own active width value. Its output is high from count 0 up to and including the width, which gives n+1 high counts out of 1024. The duty cycle therefore runs from 1/1024 up to a constant-high output and never reaches zero.

Software-side logic loads new widths through a one-word write port: a strobe, a channel index and a data word. Every write lands in a per-channel staging register. All four staging registers are copied into the active compare registers together, in the same tick that wraps the counter from its top value back to zero. A new width therefore always starts on a period boundary, and no output ever sees a partial period.

Top module: `pwm_shared_cnt`

## Requirements
- R1: While rst_ni is low, and directly after it rises, the counter is 0 and every staging and active width is 0. All four outputs are therefore high, and they go low once the count reaches 1.
- R2: The counter increments by one on a clock edge where tick_i is 1. It keeps its value on every edge where tick_i is 0.
- R3: On a tick at the top count (all ones, 1023 by default) the counter returns to 0.
- R4: The output pwm_o[c] is 1 exactly when the count is less than or equal to the active width of channel c. Over one period this is width+1 high ticks out of 1024, and a width of 1023 keeps the output constantly high.
- R5: A clock edge with wr_en_i = 1 loads wr_data_i into the staging register of channel wr_sel_i (bit c of pwm_o belongs to channel index c). The active width and the output do not change until the next wrap.
- R6: On the wrap tick of R3, all four active widths take their staging values, and the new widths govern the period that starts at count 0.
- R7: A write on the same edge as the wrap updates only the staging register. The active width takes the staging value from before that write, and the written value applies one period later.
- R8: A write to one channel leaves the staging value, active width and output of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable from the external prescaler |
| wr_en_i | input | 1 | Width write strobe |
| wr_sel_i | input | 2 | Channel index of the write |
| wr_data_i | input | 10 | Width value of the write |
| pwm_o | output | 4 | Channel outputs, bit c is channel c |

## Verification
The assertions allow any pattern on tick_i, including long runs of low and back-to-back ticks. They also allow a write on any cycle, including the wrap cycle. They take for granted only that the inputs are stable around the rising edge, which the stimulus ensures by changing every input on the falling edge. The tick patterns include continuous ticking and a gated pattern with two ticks out of every three cycles. Writes are placed mid-period, on the wrap cycle itself, and on a single channel with the other channels idle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned PWM_CNT_W = 10;
  localparam int unsigned PWM_N_CH  = 4;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pwm_tick_counter.sv
module pwm_tick_counter #(
  parameter int unsigned CNT_W = pwm_pkg::PWM_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = tick_i && (cnt_q == CNT_MAX);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_cnt_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q == CNT_MAX) |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned CNT_W = pwm_pkg::PWM_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] data_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   shadow_q <= '0;
    else if (wr_i) shadow_q <= data_i;
  end

  // copy takes pre-write shadow when write and wrap coincide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_q <= '0;
    else if (wrap_i) active_q <= shadow_q;
  end

  assign pwm_o = (cnt_i <= active_q);

  assert_shadow_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (shadow_q == $past(data_i)));
  assert_shadow_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(shadow_q));
  assert_active_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(active_q));
  assert_active_copy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> (active_q == $past(shadow_q)));
endmodule

// File: rtl/pwm_shared_cnt.sv
module pwm_shared_cnt #(
  parameter int unsigned CNT_W = pwm_pkg::PWM_CNT_W,
  parameter int unsigned N_CH  = pwm_pkg::PWM_N_CH,
  localparam int unsigned SEL_W = pwm_pkg::sel_width(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [N_CH-1:0]  pwm_o
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [N_CH-1:0]  wr_vec;

  pwm_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign wr_vec[c] = wr_en_i && (wr_sel_i == SEL_W'(c));

    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (cnt),
      .wrap_i (wrap),
      .wr_i   (wr_vec[c]),
      .data_i (wr_data_i),
      .pwm_o  (pwm_o[c])
    );
  end

  assert_high_after_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (&pwm_o));
  assert_out_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wrap) |=> $stable(pwm_o));
endmodule

// File: tb/sim_pwm_shared_cnt.sv
`timescale 1ns/1ps
module sim_pwm_shared_cnt;
  localparam int CW = 10;
  localparam int NC = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [CW-1:0] wr_data = '0;
  logic [NC-1:0] pwm;

  int tests = 0;
  int fails = 0;
  string tag = "R1";
  bit gate_mode = 1'b0;

  int cnt_m;
  int sh_m [NC];
  int act_m [NC];
  int hi_m [NC];

  always #10 clk = ~clk;

  pwm_shared_cnt u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .pwm_o(pwm)
  );

  // reference state built from R1..R7
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_m <= 0;
      for (int c = 0; c < NC; c++) begin sh_m[c] <= 0; act_m[c] <= 0; end
    end else begin
      if (tick) begin
        cnt_m <= (cnt_m == MAXC) ? 0 : cnt_m + 1;
        if (cnt_m == MAXC)
          for (int c = 0; c < NC; c++) act_m[c] <= sh_m[c];
      end
      if (wr_en) sh_m[wr_sel] <= int'(wr_data);
    end
  end

  // per-cycle output check and per-period high-count check
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      logic [NC-1:0] exp_v;
      for (int c = 0; c < NC; c++) exp_v[c] = (cnt_m <= act_m[c]);
      tests++;
      if (pwm !== exp_v) begin
        fails++;
        $display("FAIL %s count=%0d pwm actual=%b expected=%b", tag, cnt_m, pwm, exp_v);
      end
      if (tick) begin
        for (int c = 0; c < NC; c++) hi_m[c] += int'(pwm[c]);
        if (cnt_m == MAXC) begin
          for (int c = 0; c < NC; c++) begin
            tests++;
            if (hi_m[c] != act_m[c] + 1) begin
              fails++;
              $display("FAIL R4 ch%0d high ticks actual=%0d expected=%0d", c, hi_m[c], act_m[c] + 1);
            end
            hi_m[c] = 0;
          end
        end
      end
    end else begin
      for (int c = 0; c < NC; c++) hi_m[c] = 0;
    end
  end

  // tick driver: continuous, or two ticks out of three cycles
  int gcnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      gcnt <= (gcnt == 2) ? 0 : gcnt + 1;
      tick <= gate_mode ? (gcnt != 0) : 1'b1;
    end
  end

  task automatic write_ch(input int c, input int v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(c); wr_data = CW'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_count(input int v);
    do @(negedge clk); while (!(cnt_m == v && tick));
  endtask

  task automatic wait_periods(input int n);
    for (int i = 0; i < n; i++) begin
      wait_count(MAXC);
      @(negedge clk);
    end
  endtask

  task automatic check_val(input string t, input logic [NC-1:0] a, input logic [NC-1:0] e);
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", t, a, e);
    end
  endtask

  initial begin
    #5000000;
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 check_val("R1 reset outputs", pwm, 4'hF);
    rst_n = 1'b1;
    tag = "R1";
    @(negedge clk); #2 check_val("R1 after release count0", pwm, 4'hF);
    @(negedge clk); #2 check_val("R1 count1", pwm, 4'h0);
    wait_periods(1);

    // mid-period loads; stay inactive until wrap
    tag = "R5";
    wait_count(300);
    write_ch(0, 1023); write_ch(1, 511); write_ch(2, 1); write_ch(3, 1022);
    wait_count(MAXC);
    @(negedge clk);
    tag = "R3/R4/R6";
    wait_periods(1);

    tag = "R2";
    gate_mode = 1'b1;
    write_ch(0, 3); write_ch(1, 700); write_ch(2, 0); write_ch(3, 300);
    wait_periods(2);
    gate_mode = 1'b0;

    // write coinciding with the wrap tick
    tag = "R7";
    write_ch(2, 40);
    wait_periods(1);
    wait_count(MAXC);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = CW'(100);
    @(negedge clk);
    wr_en = 1'b0;
    #2 check_val("R7 new period starts high", pwm, 4'hF);
    wait_periods(2);

    tag = "R8";
    write_ch(1, 5);
    wait_periods(2);

    tag = "R4 sweep";
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < NC; c++) write_ch(c, (p * 137 + c * 251 + 1023 * (p == 7 ? 1 : 0)) % 1024);
      wait_periods(1);
    end
    wait_periods(1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule